// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a byte-addressed serial memory on a two-wire bus with a clock line and a data line. It oversamples both lines with the system clock and finds the start and stop conditions. It checks the device byte that opens each transfer and acknowledges by pulling the data line low through an open-drain enable. It keeps a word address counter and serves byte writes, page writes, current-address reads, random reads and sequential reads. The storage is an internal array of byte registers that comes out of reset with every byte set to 0xFF.

Data bytes written in one transfer collect in a page buffer. A valid stop hands that buffer to a separate write engine. The write engine copies the marked bytes into the array and holds `busy_o` high for `WR_CYCLES` clock cycles. While it is busy the slave refuses its own address, so a master can poll for the end of the write cycle. The parameter `ADDR_W` (8 to 11) sets the size of the array. The lowest `ADDR_W-8` select bits of the device byte then become upper word-address bits instead of being compared with the strap pins.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A falling data line while the clock is high is a start, and a rising data line while the clock is high is a stop. The slave changes `sda_oe_o` only while the sampled clock is low. The cycle after a stop, `sda_oe_o` is 0.
- R2: The device byte is sent MSB first. It holds type bits 7:4 = 1010, select bits 3:1 and a read flag in bit 0 (1 = read). On a match the slave drives the ninth clock low. On a mismatch it leaves the line released through the ninth clock and stays released until the next start.
- R3: With default `ADDR_W`=9, select bits 3:2 are compared with `sel_pins_i[2:1]`, and bit 1 of a write's device byte is word-address bit 8. `sel_pins_i[0]` has no effect.
- R4: In a write, the byte after the device byte is the word address, and each data byte after it is acknowledged. Data bytes go to successive offsets within the 16-byte page of that address (`PAGE_W`=4), and the offset wraps inside the page, so later bytes overwrite earlier ones.
- R5: A stop that ends a write with at least one data byte makes `busy_o` high for exactly `WR_CYCLES` cycles. While `busy_o` is high the slave acknowledges no device byte. Once it falls, the written data reads back.
- R6: The address counter holds the last accessed address plus one, wrapping within the page after a write. A read with no word address reads from the counter, and the address bits in a read's device byte are ignored.
- R7: A write that carries only a word address, followed by a repeated start and a read, returns data from that address, and `busy_o` stays low.
- R8: Read data is sent MSB first and changes after falling clock edges. Each byte the master acknowledges advances the counter to the next byte, wrapping from the last byte of the array to byte 0.
- R9: After the master does not acknowledge a read byte, the slave keeps the line released for all further clocks until a start or stop, and the counter does not move.
- R10: A stop that arrives after two or more bits of a data byte, or any start during the data phase, discards every pending byte of that write. `busy_o` then stays low and the array is unchanged.
- R11: After reset, `sda_oe_o` and `busy_o` are 0, the counter is 0 and every byte of the array is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sel_pins_i | input | 3 | Strapped select pins compared with the device byte |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| busy_o | output | 1 | Write engine is committing a page |

## Verification
The hardest situations to reach from the ports are the ones where the slave must stay silent while its own memory would drive zeros. Two cases matter: clocks after a master not-acknowledge, and a polled device byte during the write cycle. The stimulus therefore writes a page with known zero bits next to the read pointer before ending a read with a not-acknowledge. It then clocks on and requires a released line. Aborts are reached by cutting a data byte after three bits, and by a repeated start after complete data bytes. Read-back then shows that nothing reached the array.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } twi_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/twi_line_sampler.sv
module twi_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_prev;
        logic                   sda_prev;
    } samp_t;

    samp_t q, d;
    logic  scl_now, sda_now;

    assign scl_now = q.scl_sh[SYNC_STAGES-1];
    assign sda_now = q.sda_sh[SYNC_STAGES-1];

    always_comb begin
        d          = q;
        d.scl_sh   = {q.scl_sh[SYNC_STAGES-2:0], scl_i};
        d.sda_sh   = {q.sda_sh[SYNC_STAGES-2:0], sda_i};
        d.scl_prev = scl_now;
        d.sda_prev = sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl_sh: '1, sda_sh: '1, scl_prev: 1'b1, sda_prev: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign scl_o      = scl_now;
    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~q.scl_prev;
    assign scl_fall_o = ~scl_now & q.scl_prev;
    assign start_o    = scl_now & q.scl_prev & q.sda_prev & ~sda_now;
    assign stop_o     = scl_now & q.scl_prev & ~q.sda_prev & sda_now;

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/twi_page_writer.sv
module twi_page_writer #(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 256
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]           base_i,
    input  logic [(1<<PAGE_W)-1:0][7:0]        data_i,
    input  logic [(1<<PAGE_W)-1:0]             mask_i,
    output logic                               busy_o,
    output logic                               we_o,
    output logic [ADDR_W-1:0]                  waddr_o,
    output logic [7:0]                         wdata_o
);

    localparam int PAGE    = 1 << PAGE_W;
    localparam int TIMER_W = $clog2(WR_CYCLES) + 1;
    localparam logic [PAGE_W:0]    IDX_END  = (PAGE_W+1)'(PAGE);
    localparam logic [TIMER_W-1:0] TIME_END = TIMER_W'(WR_CYCLES - 1);

    typedef struct packed {
        logic               busy;
        logic [PAGE_W:0]    idx;
        logic [TIMER_W-1:0] timer;
    } wr_t;

    wr_t q, d;
    logic [PAGE_W-1:0] off;

    assign off = q.idx[PAGE_W-1:0];

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (commit_i) begin
                d.busy  = 1'b1;
                d.idx   = '0;
                d.timer = '0;
            end
        end else begin
            if (q.idx < IDX_END) begin
                d.idx = q.idx + (PAGE_W+1)'(1);
            end
            d.timer = q.timer + TIMER_W'(1);
            if (q.timer == TIME_END) begin
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o  = q.busy;
    assign we_o    = q.busy && (q.idx < IDX_END) && mask_i[off];
    assign waddr_o = {base_i, off};
    assign wdata_o = data_i[off];

    // Checker: a separate run-length counter bounds the busy window.
    logic [TIMER_W:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (q.busy) begin
            run_q <= run_q + (TIMER_W+1)'(1);
        end else begin
            run_q <= '0;
        end
    end

    assert_busy_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (run_q < (TIMER_W+1)'(WR_CYCLES)));

    assert_commit_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> !q.busy);

    assert_page_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy)) |-> ($stable(mask_i) && $stable(data_i) && $stable(base_i)));

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
    import twi_eeprom_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] sel_pins_i,
    output logic       sda_oe_o,
    output logic       busy_o
);

    localparam int UPPER_W = ADDR_W - 8;
    localparam int PAGE    = 1 << PAGE_W;
    localparam int BASE_W  = ADDR_W - PAGE_W;
    localparam logic [2:0] CMP_MASK = 3'(3'b111 << UPPER_W);

    typedef struct packed {
        twi_state_e                 st;
        twi_state_e                 ack_next;
        logic [3:0]                 cnt;
        logic [7:0]                 shreg;
        logic [2:0]                 sel;
        logic                       oe;
        logic                       mack;
        logic [ADDR_W-1:0]          addr;
        logic [BASE_W-1:0]          base;
        logic [PAGE-1:0][7:0]       pbuf;
        logic [PAGE-1:0]            mask;
        logic                       commit;
    } ctl_t;

    ctl_t q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic we;
    logic [ADDR_W-1:0] waddr;
    logic [7:0] wdata, rd_data;
    logic busy;

    twi_line_sampler #(.SYNC_STAGES(2)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    twi_mem_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (q.addr),
        .rdata_o (rd_data)
    );

    twi_page_writer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (q.commit),
        .base_i   (q.base),
        .data_i   (q.pbuf),
        .mask_i   (q.mask),
        .busy_o   (busy),
        .we_o     (we),
        .waddr_o  (waddr),
        .wdata_o  (wdata)
    );

    logic              dev_match;
    logic [ADDR_W-1:0] word_addr;
    logic [PAGE_W-1:0] off;
    logic [PAGE_W-1:0] off_nx;

    assign dev_match = (q.shreg[7:4] == DEV_TYPE) &&
                       (((q.shreg[3:1] ^ sel_pins_i) & CMP_MASK) == 3'b000);
    assign word_addr = ADDR_W'({q.sel, q.shreg});
    assign off       = q.addr[PAGE_W-1:0];
    assign off_nx    = off + PAGE_W'(1);

    always_comb begin
        d        = q;
        d.commit = 1'b0;
        if (start_c) begin
            if (q.st == ST_WDATA) begin
                d.mask = '0;
            end
            d.st  = ST_DEV;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_c) begin
            if (q.st == ST_WDATA) begin
                if (q.cnt <= 4'd1) begin
                    d.commit = |q.mask;
                end else begin
                    d.mask = '0;
                end
            end
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.shreg = {q.shreg[6:0], sda_s};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.st = ST_ACK;
                        d.oe = 1'b1;
                        if (q.st == ST_DEV) begin
                            if (dev_match && !busy) begin
                                d.sel      = q.shreg[3:1];
                                d.ack_next = q.shreg[0] ? ST_TX : ST_WADDR;
                            end else begin
                                d.st = ST_SKIP;
                                d.oe = 1'b0;
                            end
                        end else if (q.st == ST_WADDR) begin
                            d.addr     = word_addr;
                            d.base     = word_addr[ADDR_W-1:PAGE_W];
                            d.mask     = '0;
                            d.ack_next = ST_WDATA;
                        end else begin
                            d.pbuf[off] = q.shreg;
                            d.mask[off] = 1'b1;
                            d.addr      = {q.addr[ADDR_W-1:PAGE_W], off_nx};
                            d.ack_next  = ST_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        d.oe  = 1'b0;
                        d.st  = q.ack_next;
                        if (q.ack_next == ST_TX) begin
                            d.shreg = rd_data;
                            d.oe    = ~rd_data[7];
                            d.cnt   = 4'd1;
                            d.addr  = q.addr + ADDR_W'(1);
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe   = 1'b0;
                            d.st   = ST_MACK;
                            d.cnt  = '0;
                            d.mack = 1'b0;
                        end else begin
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.oe    = ~q.shreg[6];
                            d.cnt   = q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st    = ST_TX;
                            d.shreg = rd_data;
                            d.oe    = ~rd_data[7];
                            d.cnt   = 4'd1;
                            d.addr  = q.addr + ADDR_W'(1);
                        end else begin
                            d.st = ST_SKIP;
                            d.oe = 1'b0;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.ack_next <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
    assign busy_o   = busy;

    assert_oe_moves_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> !scl_s);

    assert_release_after_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !sda_oe_o);

    assert_no_ack_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DEV && scl_fall && q.cnt == 4'd8 && busy) |=> !sda_oe_o);

    assert_skip_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SKIP && $past(q.st) == ST_SKIP) |-> !sda_oe_o);

    assert_read_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_TX && $past(q.st) != ST_TX) |-> (q.addr == $past(q.addr) + ADDR_W'(1)));

    assert_page_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ACK && $past(q.st) == ST_WDATA) |->
        (q.addr[ADDR_W-1:PAGE_W] == $past(q.addr[ADDR_W-1:PAGE_W])));

endmodule

// File: tb/tb_twi_eeprom_slave.sv
module tb_twi_eeprom_slave;

    localparam int ADDR_W    = 9;
    localparam int PAGE_W    = 4;
    localparam int WR_CYCLES = 256;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int PAGE      = 1 << PAGE_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic msda = 1'b1;
    logic [2:0] pins = 3'b101;
    logic sda_oe, busy;
    logic sda_line;

    always #4 clk = ~clk;

    assign sda_line = msda & ~sda_oe;

    twi_eeprom_slave #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sel_pins_i (pins),
        .sda_oe_o   (sda_oe),
        .busy_o     (busy)
    );

    int tests = 0;
    int fails = 0;
    int mem_m [DEPTH];
    int ptr_m = 0;
    int run_len = 0;
    int last_len = 0;

    // Every-clock monitor of the busy window length.
    always @(posedge clk) begin
        if (busy) begin
            run_len <= run_len + 1;
        end else if (run_len > 0) begin
            last_len <= run_len;
            run_len  <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic line);
        msda = b;
        wt(4);
        scl = 1'b1;
        wt(4);
        line = sda_line;
        wt(4);
        scl = 1'b0;
        wt(4);
    endtask

    task automatic do_start();
        msda = 1'b1;
        wt(4);
        scl = 1'b1;
        wt(4);
        msda = 1'b0;
        wt(4);
        scl = 1'b0;
        wt(4);
    endtask

    task automatic do_stop();
        msda = 1'b0;
        wt(4);
        scl = 1'b1;
        wt(4);
        msda = 1'b1;
        wt(8);
    endtask

    function automatic logic [7:0] devb(input logic [2:0] sel, input logic rd);
        return {4'b1010, sel, rd};
    endfunction

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic line;
        bit quiet = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(b[i], line);
            if (line !== b[i]) quiet = 1'b0;
        end
        chk(quiet, "R1", int'(quiet), 1, "line free while master sends");
        clk_bit(1'b1, line);
        chk(line === (exp_ack ? 1'b0 : 1'b1), req, int'(line), exp_ack ? 0 : 1, "ack bit");
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit ack, input string req);
        logic line;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, line);
            got[i] = line;
        end
        chk(got === exp, req, int'(got), int'(exp), "read byte");
        clk_bit(ack ? 1'b0 : 1'b1, line);
    endtask

    task automatic quiet_clocks(input int n, input string req);
        logic line;
        bit all_high = 1'b1;
        for (int i = 0; i < n; i++) begin
            clk_bit(1'b1, line);
            if (line !== 1'b1) all_high = 1'b0;
        end
        chk(all_high, req, int'(all_high), 1, "line released on extra clocks");
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 5000) begin
            wt(1);
            n++;
        end
        wt(2);
        chk(!busy, req, int'(busy), 0, "busy cleared");
        chk(last_len == WR_CYCLES, req, last_len, WR_CYCLES, "busy length");
    endtask

    task automatic page_write(input logic upper, input logic [7:0] wa, input logic [7:0] data[$]);
        int a = {23'd0, upper, wa};
        do_start();
        send_byte(devb({pins[2:1], upper}, 1'b0), 1'b1, "R4");
        send_byte(wa, 1'b1, "R4");
        foreach (data[k]) begin
            send_byte(data[k], 1'b1, "R4");
            mem_m[a] = int'(data[k]);
            a = (a & ~(PAGE - 1)) | ((a + 1) & (PAGE - 1));
        end
        ptr_m = a;
        do_stop();
        chk(busy === 1'b1, "R5", int'(busy), 1, "busy after stop");
        do_start();
        send_byte(devb({pins[2:1], upper}, 1'b1), 1'b0, "R5");
        do_stop();
        wait_idle("R5");
    endtask

    task automatic cur_read(input int n, input string req);
        do_start();
        send_byte(devb({pins[2:1], 1'b0}, 1'b1), 1'b1, req);
        for (int k = 0; k < n; k++) begin
            recv_byte(8'(mem_m[ptr_m]), k < n - 1, req);
            ptr_m = (ptr_m + 1) % DEPTH;
        end
    endtask

    task automatic rand_read(input logic upper, input logic [7:0] wa, input logic rd_upper,
                             input int n, input string req);
        do_start();
        send_byte(devb({pins[2:1], upper}, 1'b0), 1'b1, req);
        send_byte(wa, 1'b1, req);
        ptr_m = {23'd0, upper, wa};
        do_start();
        send_byte(devb({pins[2:1], rd_upper}, 1'b1), 1'b1, req);
        for (int k = 0; k < n; k++) begin
            recv_byte(8'(mem_m[ptr_m]), k < n - 1, req);
            ptr_m = (ptr_m + 1) % DEPTH;
        end
        do_stop();
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [7:0] pg[$];
        logic line;
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
        wt(5);
        chk(sda_oe === 1'b0, "R11", int'(sda_oe), 0, "oe after reset");
        chk(busy === 1'b0, "R11", int'(busy), 0, "busy after reset");
        rst_n = 1'b1;
        wt(10);

        // R11 / R6: counter starts at 0, array erased
        cur_read(1, "R11");
        do_stop();
        chk(ptr_m == 1, "R6", ptr_m, 1, "model counter");

        // R4 / R5: single byte write
        pg = '{8'h3C};
        page_write(1'b0, 8'h05, pg);

        // R6: current read follows last write + 1
        cur_read(1, "R6");
        do_stop();

        // R7: dummy write then read
        rand_read(1'b0, 8'h05, 1'b0, 1, "R7");
        wt(10);
        chk(busy === 1'b0, "R7", int'(busy), 0, "no write cycle after dummy write");

        // R4 / R3: page write in upper half, with rollover inside the page
        pg = {};
        for (int i = 0; i < 18; i++) pg.push_back(8'(8'h40 + i));
        page_write(1'b1, 8'hFE, pg);
        chk(ptr_m == 9'h1F0, "R4", ptr_m, 9'h1F0, "model counter wrapped in page");

        // R6 + R9: counter wrapped to page start; nack then extra clocks
        cur_read(1, "R6");
        quiet_clocks(9, "R9");
        do_stop();
        cur_read(1, "R9");
        do_stop();

        // R8: sequential read across the end of the array, read device bits ignored (R6)
        rand_read(1'b1, 8'hFE, 1'b0, 4, "R8");

        // R2: mismatching select bits and wrong device type
        do_start();
        send_byte(devb({~pins[2], pins[1], 1'b0}, 1'b1), 1'b0, "R2");
        quiet_clocks(9, "R2");
        do_stop();
        do_start();
        send_byte(8'b1011_1010, 1'b0, "R2");
        do_stop();

        // R3: the unused strap pin has no effect
        pins = 3'b100;
        wt(4);
        cur_read(1, "R3");
        do_stop();
        pins = 3'b101;
        wt(4);

        // R10: stop in the middle of a data byte
        do_start();
        send_byte(devb({pins[2:1], 1'b0}, 1'b0), 1'b1, "R10");
        send_byte(8'h10, 1'b1, "R10");
        send_byte(8'h11, 1'b1, "R10");
        send_byte(8'h22, 1'b1, "R10");
        clk_bit(1'b0, line);
        clk_bit(1'b1, line);
        clk_bit(1'b0, line);
        do_stop();
        wt(20);
        chk(busy === 1'b0, "R10", int'(busy), 0, "no commit after cut byte");
        rand_read(1'b0, 8'h10, 1'b0, 2, "R10");

        // R10: repeated start after complete data bytes
        do_start();
        send_byte(devb({pins[2:1], 1'b0}, 1'b0), 1'b1, "R10");
        send_byte(8'h20, 1'b1, "R10");
        send_byte(8'h55, 1'b1, "R10");
        send_byte(8'h66, 1'b1, "R10");
        ptr_m = 9'h022;
        cur_read(1, "R10");
        do_stop();
        wt(20);
        chk(busy === 1'b0, "R10", int'(busy), 0, "no commit after repeated start");
        rand_read(1'b0, 8'h20, 1'b0, 2, "R10");

        report();
    end

endmodule